// File: doc/BRIEF.md
# Packed Byte-Lane Media ALU

This block is a 32-bit packed arithmetic unit for video-coding inner loops. Each operation takes two 32-bit operands and a 4-bit opcode. Some operations return a vector of byte or halfword lanes. Others reduce the four byte lanes to one scalar: sum of absolute differences, or an unsigned-by-signed multiply-sum.

An operation is issued by raising `in_valid` with the opcode and operands. One clock later, `out_valid` rises and `out_result` carries the answer. The result register loads only on valid issues, so it keeps its value between them.

Top module: `pkmedia_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.
- R2: `out_valid` equals `in_valid` of the previous clock. When `in_valid` was low, `out_result` keeps its previous value.
- R3: Opcode 0 (lane absolute difference): each byte lane i of the result is |A.i − B.i|, with both bytes taken as unsigned.
- R4: Opcode 1 (SAD): the result is the sum of the four unsigned byte absolute differences, zero-extended to 32 bits. It never exceeds 1020.
- R5: Opcode 2 (multiply-sum): the result is the sum over the four lanes of unsigned A.i × signed B.i, sign-extended to 32 bits.
- R6: Opcode 3 (halfword add): each 16-bit lane of the result is (A.h + B.h) mod 2^16. No carry passes from the low lane into the high lane.
- R7: Opcode 4 (halfword subtract): each 16-bit lane of the result is (A.h − B.h) mod 2^16. No borrow passes between the lanes.
- R8: Opcode 5 (pair average): each byte lane of the result is (A.i + B.i + 1) >> 1, unsigned.
- R9: Opcode 6 (four-way average): result byte k, for k = 0 and 1, is (A.2k + A.2k+1 + B.2k + B.2k+1 + 2) >> 2. Bytes 2 and 3 of the result are 0.
- R10: Opcode 7 (pack): the result bytes, from most to least significant, are {B byte 2, B byte 0, A byte 2, A byte 0}. These are the low bytes of each halfword.
- R11: Opcodes 8 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 4 | Opcode |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 32 | Registered result |

## Verification
Two situations are hard to reach with random operands. One is the extremes of the reductions: a SAD of exactly 1020 and a multiply-sum of −130560 or +129540. The other is a halfword operation whose low lane overflows or underflows while the high lane must stay unaffected. Directed vectors place all four lanes at 0xFF/0x00 or 0xFF/0x80, and pair 0xFFFF with 1 and 0 with 1, before the random phase starts. The random phase mixes idle cycles with issues, so that the hold behaviour of the result register is covered across all sixteen opcodes.

// File: rtl/pkmedia_alu.sv
module pkmedia_alu #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  parameter int OPW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [OPW-1:0]        in_op,
  input  logic [LANES*BW-1:0]   in_a,
  input  logic [LANES*BW-1:0]   in_b,
  output logic                  out_valid,
  output logic [LANES*BW-1:0]   out_result
);
  localparam int DW = LANES * BW;
  localparam int HL = LANES / 2;
  localparam int HW = 2 * BW;
  localparam int SW = BW + $clog2(LANES) + 1;
  localparam int MW = 2 * BW + 1 + $clog2(LANES) + 1;

  localparam logic [OPW-1:0] OP_ABSD = OPW'(0);
  localparam logic [OPW-1:0] OP_SAD  = OPW'(1);
  localparam logic [OPW-1:0] OP_MSUM = OPW'(2);
  localparam logic [OPW-1:0] OP_HADD = OPW'(3);
  localparam logic [OPW-1:0] OP_HSUB = OPW'(4);
  localparam logic [OPW-1:0] OP_AVG2 = OPW'(5);
  localparam logic [OPW-1:0] OP_AVG4 = OPW'(6);
  localparam logic [OPW-1:0] OP_PACK = OPW'(7);

  logic [BW-1:0]          a_b [LANES];
  logic [BW-1:0]          b_b [LANES];
  logic [BW-1:0]          absd [LANES];
  logic [BW-1:0]          avg2 [LANES];
  logic signed [2*BW:0]   prod [LANES];
  logic [DW-1:0]          absd_v, avg2_v, hadd_v, hsub_v, avg4_v, pack_v;
  logic [SW-1:0]          sad_sum;
  logic signed [MW-1:0]   msum;
  logic [DW-1:0]          nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BW:0] pair;
    assign a_b[i]  = in_a[i*BW +: BW];
    assign b_b[i]  = in_b[i*BW +: BW];
    assign absd[i] = (a_b[i] > b_b[i]) ? a_b[i] - b_b[i] : b_b[i] - a_b[i];
    assign pair    = {1'b0, a_b[i]} + {1'b0, b_b[i]} + {{BW{1'b0}}, 1'b1};
    assign avg2[i] = pair[BW:1];
    assign prod[i] = $signed({{BW{1'b0}}, a_b[i]}) *
                     $signed({{(BW+1){b_b[i][BW-1]}}, b_b[i]});
    assign absd_v[i*BW +: BW] = absd[i];
    assign avg2_v[i*BW +: BW] = avg2[i];
  end

  for (genvar h = 0; h < HL; h++) begin : g_half
    logic [BW+1:0] quad;
    assign hadd_v[h*HW +: HW] = in_a[h*HW +: HW] + in_b[h*HW +: HW];
    assign hsub_v[h*HW +: HW] = in_a[h*HW +: HW] - in_b[h*HW +: HW];
    assign quad = {2'b00, a_b[2*h]} + {2'b00, a_b[2*h+1]} +
                  {2'b00, b_b[2*h]} + {2'b00, b_b[2*h+1]} + (BW+2)'(2);
    assign avg4_v[h*BW +: BW]      = quad[BW+1:2];
    assign avg4_v[(HL+h)*BW +: BW] = '0;
    assign pack_v[h*BW +: BW]      = a_b[2*h];
    assign pack_v[(HL+h)*BW +: BW] = b_b[2*h];
  end

  always_comb begin
    sad_sum = '0;
    msum    = '0;
    for (int i = 0; i < LANES; i++) begin
      sad_sum = sad_sum + SW'(absd[i]);
      msum    = msum + MW'(prod[i]);
    end
  end

  always_comb begin
    case (in_op)
      OP_ABSD: nxt = absd_v;
      OP_SAD:  nxt = DW'(sad_sum);
      OP_MSUM: nxt = DW'(msum);
      OP_HADD: nxt = hadd_v;
      OP_HSUB: nxt = hsub_v;
      OP_AVG2: nxt = avg2_v;
      OP_AVG4: nxt = avg4_v;
      OP_PACK: nxt = pack_v;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt;
    end
  end
endmodule

// File: rtl/pkmedia_alu_chk.sv
module pkmedia_alu_chk #(
  parameter int DW  = 32,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] in_op,
  input logic           out_valid,
  input logic [DW-1:0]  out_result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R2
  AST_SAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OPW'(1)) |=> (out_result <= DW'(1020))); // R4
  AST_MSUM_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OPW'(2)) |=>
      (out_result[DW-1:DW-15] == '0 || out_result[DW-1:DW-15] == '1)); // R5
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op > OPW'(7)) |=> (out_result == '0)); // R11
endmodule

bind pkmedia_alu pkmedia_alu_chk #(.DW(LANES*BW), .OPW(OPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/pkmedia_alu_tb_top.sv
module pkmedia_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int total = 0, bad = 0;
  logic        exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  string       tag_v = "R1", tag_r = "R1";

  always #2 clk = ~clk;

  pkmedia_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] ref_op(int op, logic [31:0] a, logic [31:0] b);
    int s;
    logic [31:0] r;
    int ab [4], bb [4];
    for (int i = 0; i < 4; i++) begin
      ab[i] = int'(a[8*i +: 8]);
      bb[i] = int'(b[8*i +: 8]);
    end
    r = '0;
    case (op)
      0: for (int i = 0; i < 4; i++) begin
           s = ab[i] - bb[i];
           r[8*i +: 8] = 8'(s < 0 ? -s : s);
         end
      1: begin
           s = 0;
           for (int i = 0; i < 4; i++) s += (ab[i] > bb[i]) ? ab[i] - bb[i] : bb[i] - ab[i];
           r = 32'(s);
         end
      2: begin
           s = 0;
           for (int i = 0; i < 4; i++) s += ab[i] * (bb[i] > 127 ? bb[i] - 256 : bb[i]);
           r = 32'(s);
         end
      3: for (int h = 0; h < 2; h++)
           r[16*h +: 16] = 16'((int'(a[16*h +: 16]) + int'(b[16*h +: 16])) % 65536);
      4: for (int h = 0; h < 2; h++)
           r[16*h +: 16] = 16'((int'(a[16*h +: 16]) - int'(b[16*h +: 16]) + 65536) % 65536);
      5: for (int i = 0; i < 4; i++) r[8*i +: 8] = 8'((ab[i] + bb[i] + 1) / 2);
      6: for (int k = 0; k < 2; k++)
           r[8*k +: 8] = 8'((ab[2*k] + ab[2*k+1] + bb[2*k] + bb[2*k+1] + 2) / 4);
      7: r = {b[23:16], b[7:0], a[23:16], a[7:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R3";  1: return "R4";  2: return "R5";  3: return "R6";
      4: return "R7";  5: return "R8";  6: return "R9";  7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic step(logic rst, logic v, int op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    total++;
    if (out_valid !== exp_v) begin
      bad++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag_v, out_valid, exp_v);
    end
    total++;
    if (out_result !== exp_r) begin
      bad++;
      $display("FAIL %s out_result actual=%h expected=%h", tag_r, out_result, exp_r);
    end
    rst_n = rst; in_valid = v; in_op = 4'(op); in_a = a; in_b = b;
    if (!rst) begin
      exp_v = 1'b0; exp_r = '0; tag_v = "R1"; tag_r = "R1";
    end else begin
      exp_v = v; tag_v = "R2";
      if (v) begin exp_r = ref_op(op, a, b); tag_r = op_tag(op); end
      else tag_r = "R2";
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(0, 1, 1, 32'hFFFF_FFFF, 0);                      // R1 reset holds outputs low
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 32'h10F0_0380, 32'h2010_0380);          // R3
    step(1, 1, 1, 32'hFFFF_FFFF, 32'h0000_0000);          // R4 max 1020
    step(1, 1, 1, 32'h0102_0304, 32'h0403_0201);          // R4
    step(1, 1, 2, 32'hFFFF_FFFF, 32'h8080_8080);          // R5 most negative
    step(1, 1, 2, 32'hFFFF_FFFF, 32'h7F7F_7F7F);          // R5 most positive
    step(1, 1, 3, 32'h0001_FFFF, 32'h0000_0001);          // R6 no carry across
    step(1, 1, 4, 32'h0005_0000, 32'h0000_0001);          // R7 no borrow across
    step(1, 1, 5, 32'hFF00_01FE, 32'hFE00_00FF);          // R8 round up
    step(1, 1, 6, 32'hFFFF_0102, 32'hFFFF_0100);          // R9
    step(1, 1, 7, 32'h1122_3344, 32'h5566_7788);          // R10
    step(1, 0, 9, 32'h1234_5678, 32'h9ABC_DEF0);          // R2 hold
    step(1, 1, 8, 32'hFFFF_FFFF, 32'h1);                  // R11
    step(1, 1, 15, 32'h1, 32'hFFFF_FFFF);                 // R11
    for (int n = 0; n < 4000; n++)
      step(1, ($urandom % 4) != 0, int'($urandom % 16), $urandom, $urandom);
    step(1, 0, 0, 0, 0);
    finish_run();
  end
endmodule